// File: doc/BRIEF.md
# USB Device Suspend, Reset and Interrupt Mask Registers

This block holds two 8-bit software-visible registers for a USB device interface. The first is an interrupt mask. The second is a control word that software and hardware both write. The mask is ANDed bit by bit with interrupt status flags that arrive from an external status register. The result is then gated by the CPU's global interrupt-disable bit to form a single interrupt request.

The control word has two hardware-set flags, which record that a resume or a reset sequence has started on the bus. It also has four software controls:
- a resume-drive output, which signals resume to the host;
- a regulator power-down output;
- a forced-suspend output, which hardware clears when the bus shows activity;
- a forced-reset output, which holds the interface in reset.

When software releases forced reset, the block emits a one-cycle USB-reset event pulse. The external status register latches this pulse.

Software reaches both registers through a one-cycle write strobe and a one-bit address: 0 selects the mask and 1 selects the control word. Read data is combinational. Reset is synchronous and active high.

Top module: `usb_ctl_regs`

## Requirements
- R1: After reset, the mask register reads 0x00 and the control register reads 0x06. So power-down and forced-suspend are 1, all other bits are 0, and the interrupt request is 0.
- R2: A write at address 0 stores the mask. Bit 6 of the mask is not stored and always reads 0. Mask bits: 7 control transfer, 5 overrun, 4 error, 3 suspend, 2 end of suspend, 1 reset, 0 start of frame.
- R3: The interrupt request is 1 exactly when some bit position has both the mask bit and the status input bit at 1, and the CPU interrupt-disable input is 0. Because mask bit 6 never holds a 1, status bit 6 alone never requests an interrupt.
- R4: Control bits 5:4 are reserved. They always read 0, and writes to them have no effect.
- R5: Control bit 7 (resume seen) is set in the cycle after a resume-start input pulse. Control bit 6 (reset seen) is set in the cycle after a reset-start input pulse. Writing 1 to either bit has no effect.
- R6: A control write with 0 in bit 7 or bit 6 clears that flag. If a hardware set arrives in the same cycle as such a clearing write, the flag ends up set.
- R7: Control bit 1 (forced suspend) drives the forced-suspend output. Software may set or clear it. A bus-activity input clears it in the next cycle, and this clear wins over a software write of 1 in the same cycle.
- R8: Control bit 0 (forced reset) drives the forced-reset output. On each 1-to-0 change of this bit, the USB-reset event output is 1 for exactly one cycle: the first cycle in which the bit reads 0. Otherwise the event output is 0.
- R9: Control bit 3 (resume drive) and control bit 2 (power down) drive their outputs. They change only through software writes. Bus activity and the flag inputs leave them unchanged.
- R10: Read data is combinational. It shows the register selected by the current address, in the same cycle the address changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | One-cycle write strobe |
| addr_i | input | 1 | Register select: 0 mask, 1 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data of the selected register |
| irq_status_i | input | 8 | Interrupt status flags from the external status register |
| cpu_irq_dis_i | input | 1 | CPU global interrupt disable |
| bus_resume_start_i | input | 1 | Pulse: resume sequence began on the bus |
| bus_reset_start_i | input | 1 | Pulse: reset sequence began on the bus |
| bus_activity_i | input | 1 | Pulse: activity seen on the bus |
| irq_req_o | output | 1 | Interrupt request |
| resume_drive_o | output | 1 | Drive resume signalling on the bus |
| pwr_down_o | output | 1 | Turn the transceiver regulator off |
| force_suspend_o | output | 1 | Interface in forced suspend |
| force_reset_o | output | 1 | Interface held in reset |
| usb_reset_evt_o | output | 1 | One-cycle pulse when forced reset is released |

## Verification
Several properties hold on every cycle and are checked continuously:
- the interrupt combine, compared against the read-back mask;
- the zero reserved and mask-bit-6 read positions;
- the flag sets after start pulses, with hardware priority over clears;
- the clear of forced suspend after bus activity;
- the stability of resume drive and power down when there is no control write;
- the single-cycle shape of the reset event and its tie to a falling forced reset.

Other behaviours only the bench's scenarios can show:
- the reset values;
- a written 1 failing to set a flag;
- software clearing forced suspend;
- the combinational response of read data to the address alone;
- a range of mask and status patterns, including the disable gate.

// File: rtl/usb_ctl_pkg.sv
package usb_ctl_pkg;

    localparam int REG_W = 8;

    // control word bit positions (decoded by software)
    localparam int CB_RES_SEEN = 7;
    localparam int CB_RST_SEEN = 6;
    localparam int CB_RESUME   = 3;
    localparam int CB_PDWN     = 2;
    localparam int CB_FSUSP    = 1;
    localparam int CB_FRES     = 0;

    localparam logic [REG_W-1:0] CTRL_RST_VAL = 8'h06;
    localparam logic [REG_W-1:0] MASK_KEEP    = 8'hBF;
    localparam logic [REG_W-1:0] CTRL_KEEP    = 8'hCF;

    localparam logic ADDR_MASK = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    typedef struct packed {
        logic res_seen;
        logic rst_seen;
        logic resume_drv;
        logic pdwn;
        logic fsusp;
        logic fres;
        logic evt;
    } ctrl_state_t;

    typedef struct packed {
        logic [REG_W-1:0] bits;
    } mask_state_t;

endpackage

// File: rtl/usb_ctl_mask_reg.sv
module usb_ctl_mask_reg
    import usb_ctl_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);

    mask_state_t mask_d, mask_q;
    logic [W-1:0] wkeep;

    assign wkeep = wdata_i & MASK_KEEP;

    always_comb begin
        mask_d = mask_q;
        if (wr_i) begin
            mask_d.bits = wkeep;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mask_q.bits <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask_o = mask_q.bits;

endmodule

// File: rtl/usb_ctl_ctrl_reg.sv
module usb_ctl_ctrl_reg
    import usb_ctl_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         res_start_i,
    input  logic         rst_start_i,
    input  logic         activity_i,
    output logic [W-1:0] ctrl_o,
    output logic         evt_o
);

    ctrl_state_t st_d, st_q;
    logic [W-1:0] wkeep;

    assign wkeep = wdata_i & CTRL_KEEP;

    always_comb begin
        st_d = st_q;

        // software writes: flags only accept a clearing 0
        if (wr_i) begin
            if (!wkeep[CB_RES_SEEN]) st_d.res_seen = 1'b0;
            if (!wkeep[CB_RST_SEEN]) st_d.rst_seen = 1'b0;
            st_d.resume_drv = wkeep[CB_RESUME];
            st_d.pdwn       = wkeep[CB_PDWN];
            st_d.fsusp      = wkeep[CB_FSUSP];
            st_d.fres       = wkeep[CB_FRES];
        end

        // hardware events take priority over software
        if (res_start_i) st_d.res_seen = 1'b1;
        if (rst_start_i) st_d.rst_seen = 1'b1;
        if (activity_i)  st_d.fsusp    = 1'b0;

        // release of forced reset raises the event
        st_d.evt = st_q.fres & ~st_d.fres;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.res_seen   <= CTRL_RST_VAL[CB_RES_SEEN];
            st_q.rst_seen   <= CTRL_RST_VAL[CB_RST_SEEN];
            st_q.resume_drv <= CTRL_RST_VAL[CB_RESUME];
            st_q.pdwn       <= CTRL_RST_VAL[CB_PDWN];
            st_q.fsusp      <= CTRL_RST_VAL[CB_FSUSP];
            st_q.fres       <= CTRL_RST_VAL[CB_FRES];
            st_q.evt        <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_o              = '0;
        ctrl_o[CB_RES_SEEN] = st_q.res_seen;
        ctrl_o[CB_RST_SEEN] = st_q.rst_seen;
        ctrl_o[CB_RESUME]   = st_q.resume_drv;
        ctrl_o[CB_PDWN]     = st_q.pdwn;
        ctrl_o[CB_FSUSP]    = st_q.fsusp;
        ctrl_o[CB_FRES]     = st_q.fres;
    end

    assign evt_o = st_q.evt;

endmodule

// File: rtl/usb_ctl_irq_comb.sv
module usb_ctl_irq_comb #(
    parameter int N = 8
) (
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] status_i,
    input  logic         dis_i,
    output logic         irq_o
);

    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_hit
        assign hit[g] = mask_i[g] & status_i[g];
    end

    assign irq_o = (|hit) & ~dis_i;

endmodule

// File: rtl/usb_ctl_regs.sv
module usb_ctl_regs
    import usb_ctl_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic             addr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    input  logic [REG_W-1:0] irq_status_i,
    input  logic             cpu_irq_dis_i,
    input  logic             bus_resume_start_i,
    input  logic             bus_reset_start_i,
    input  logic             bus_activity_i,
    output logic             irq_req_o,
    output logic             resume_drive_o,
    output logic             pwr_down_o,
    output logic             force_suspend_o,
    output logic             force_reset_o,
    output logic             usb_reset_evt_o
);

    logic [REG_W-1:0] mask_view;
    logic [REG_W-1:0] ctrl_view;
    logic             wr_mask, wr_ctrl;

    assign wr_mask = wr_en_i & (addr_i == ADDR_MASK);
    assign wr_ctrl = wr_en_i & (addr_i == ADDR_CTRL);

    usb_ctl_mask_reg #(.W(REG_W)) mask_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_i    (wr_mask),
        .wdata_i (wdata_i),
        .mask_o  (mask_view)
    );

    usb_ctl_ctrl_reg #(.W(REG_W)) ctrl_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .wr_i        (wr_ctrl),
        .wdata_i     (wdata_i),
        .res_start_i (bus_resume_start_i),
        .rst_start_i (bus_reset_start_i),
        .activity_i  (bus_activity_i),
        .ctrl_o      (ctrl_view),
        .evt_o       (usb_reset_evt_o)
    );

    usb_ctl_irq_comb #(.N(REG_W)) irq_i (
        .mask_i   (mask_view),
        .status_i (irq_status_i),
        .dis_i    (cpu_irq_dis_i),
        .irq_o    (irq_req_o)
    );

    assign rdata_o         = (addr_i == ADDR_CTRL) ? ctrl_view : mask_view;
    assign resume_drive_o  = ctrl_view[CB_RESUME];
    assign pwr_down_o      = ctrl_view[CB_PDWN];
    assign force_suspend_o = ctrl_view[CB_FSUSP];
    assign force_reset_o   = ctrl_view[CB_FRES];

endmodule

// File: rtl/usb_ctl_regs_chk.sv
module usb_ctl_regs_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       wr_en_i,
    input logic       addr_i,
    input logic [7:0] wdata_i,
    input logic [7:0] rdata_o,
    input logic [7:0] irq_status_i,
    input logic       cpu_irq_dis_i,
    input logic       bus_resume_start_i,
    input logic       bus_reset_start_i,
    input logic       bus_activity_i,
    input logic       irq_req_o,
    input logic       resume_drive_o,
    input logic       pwr_down_o,
    input logic       force_suspend_o,
    input logic       force_reset_o,
    input logic       usb_reset_evt_o,
    input logic [7:0] ctrl_view
);

    p_irq_combine_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (addr_i == 1'b0) |-> (irq_req_o == ((|(rdata_o & irq_status_i)) && !cpu_irq_dis_i)));

    p_mask_bit6_zero_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (addr_i == 1'b0) |-> (rdata_o[6] == 1'b0));

    p_rsvd_zero_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (addr_i == 1'b1) |-> (rdata_o[5:4] == 2'b00));

    p_resume_seen_set_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_resume_start_i |=> ctrl_view[7]);

    p_reset_seen_wins_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_reset_start_i && wr_en_i && addr_i && !wdata_i[6]) |=> ctrl_view[6]);

    p_suspend_cleared_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_activity_i |=> !force_suspend_o);

    p_evt_one_cycle_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        usb_reset_evt_o |=> !usb_reset_evt_o);

    p_evt_on_release_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(force_reset_o) |-> usb_reset_evt_o);

    p_evt_needs_release_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        usb_reset_evt_o |-> !force_reset_o);

    p_sw_only_bits_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !(wr_en_i && addr_i) |=> ($stable(resume_drive_o) && $stable(pwr_down_o)));

endmodule

bind usb_ctl_regs usb_ctl_regs_chk chk_i (
    .clk_i              (clk_i),
    .rst_i              (rst_i),
    .wr_en_i            (wr_en_i),
    .addr_i             (addr_i),
    .wdata_i            (wdata_i),
    .rdata_o            (rdata_o),
    .irq_status_i       (irq_status_i),
    .cpu_irq_dis_i      (cpu_irq_dis_i),
    .bus_resume_start_i (bus_resume_start_i),
    .bus_reset_start_i  (bus_reset_start_i),
    .bus_activity_i     (bus_activity_i),
    .irq_req_o          (irq_req_o),
    .resume_drive_o     (resume_drive_o),
    .pwr_down_o         (pwr_down_o),
    .force_suspend_o    (force_suspend_o),
    .force_reset_o      (force_reset_o),
    .usb_reset_evt_o    (usb_reset_evt_o),
    .ctrl_view          (ctrl_view)
);

// File: tb/usb_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module usb_ctl_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] status = '0;
    logic       dis = 1'b0;
    logic       res_start = 1'b0;
    logic       rst_start = 1'b0;
    logic       activity = 1'b0;
    logic       irq, resume_drv, pdwn, fsusp, fres, evt;

    int runs = 0;
    int fails = 0;

    always #10 clk = ~clk;

    usb_ctl_regs dut_i (
        .clk_i              (clk),
        .rst_i              (rst),
        .wr_en_i            (wr_en),
        .addr_i             (addr),
        .wdata_i            (wdata),
        .rdata_o            (rdata),
        .irq_status_i       (status),
        .cpu_irq_dis_i      (dis),
        .bus_resume_start_i (res_start),
        .bus_reset_start_i  (rst_start),
        .bus_activity_i     (activity),
        .irq_req_o          (irq),
        .resume_drive_o     (resume_drv),
        .pwr_down_o         (pdwn),
        .force_suspend_o    (fsusp),
        .force_reset_o      (fres),
        .usb_reset_evt_o    (evt)
    );

    // {mask write, status, disable, expected mask read, expected irq}
    localparam logic [25:0] VEC [9] = '{
        {8'h00, 8'hFF, 1'b0, 8'h00, 1'b0},
        {8'h01, 8'h01, 1'b0, 8'h01, 1'b1},
        {8'h01, 8'h01, 1'b1, 8'h01, 1'b0},
        {8'hFF, 8'h40, 1'b0, 8'hBF, 1'b0},
        {8'h80, 8'h7F, 1'b0, 8'h80, 1'b0},
        {8'h80, 8'h80, 1'b0, 8'h80, 1'b1},
        {8'h24, 8'h04, 1'b0, 8'h24, 1'b1},
        {8'h24, 8'hDB, 1'b0, 8'h24, 1'b0},
        {8'h3E, 8'h02, 1'b0, 8'h3E, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        runs++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); chk("R1 mask reset", v, 8'h00);
        rd(1'b1, v); chk("R1 ctrl reset", v, 8'h06);
        chk("R1 outputs", {3'b0, irq, pdwn, fsusp, fres, evt}, 8'h0C);

        // R2 / R3 table walk
        for (int i = 0; i < 9; i++) begin
            wr(1'b0, VEC[i][25:18]);
            status = VEC[i][17:10];
            dis    = VEC[i][9];
            rd(1'b0, v);
            chk("R2 mask readback", v, VEC[i][8:1]);
            chk("R3 irq", {7'b0, irq}, {7'b0, VEC[i][0]});
        end
        status = '0; dis = 1'b0;

        // R10 combinational address switch
        addr = 1'b1; #1; chk("R10 ctrl sel", rdata, 8'h06);
        addr = 1'b0; #1; chk("R10 mask sel", rdata, 8'h3E);

        // R4 / R5 write all ones: reserved and flags unchanged
        wr(1'b1, 8'hFF);
        rd(1'b1, v); chk("R4 R5 write ones", v, 8'h0F);
        chk("R8 force reset held", {7'b0, fres}, 8'h01);
        chk("R8 no event while held", {7'b0, evt}, 8'h00);

        // R8 release -> one cycle pulse
        wr(1'b1, 8'h0E);
        chk("R8 event pulse", {7'b0, evt}, 8'h01);
        @(negedge clk);
        chk("R8 event ends", {7'b0, evt}, 8'h00);

        // R7 / R9 activity clears suspend only
        @(negedge clk); activity = 1'b1;
        @(negedge clk); activity = 1'b0;
        chk("R7 activity clears", {7'b0, fsusp}, 8'h00);
        chk("R9 drive and pdwn kept", {6'b0, resume_drv, pdwn}, 8'h03);

        // R7 activity beats software set
        @(negedge clk); wr_en = 1'b1; addr = 1'b1; wdata = 8'h02; activity = 1'b1;
        @(negedge clk); wr_en = 1'b0; activity = 1'b0;
        chk("R7 activity wins", {7'b0, fsusp}, 8'h00);

        // R7 software set then clear
        wr(1'b1, 8'h02);
        chk("R7 sw set", {7'b0, fsusp}, 8'h01);
        wr(1'b1, 8'h00);
        chk("R7 sw clear", {7'b0, fsusp}, 8'h00);
        chk("R9 sw clear", {6'b0, resume_drv, pdwn}, 8'h00);

        // R5 flags set by hardware
        @(negedge clk); res_start = 1'b1;
        @(negedge clk); res_start = 1'b0; rst_start = 1'b1;
        @(negedge clk); rst_start = 1'b0;
        rd(1'b1, v); chk("R5 flags set", v, 8'hC0);

        // R6 written 1 keeps, written 0 clears
        wr(1'b1, 8'hC0);
        rd(1'b1, v); chk("R6 ones keep flags", v, 8'hC0);
        wr(1'b1, 8'h40);
        rd(1'b1, v); chk("R6 zero clears bit7", v, 8'h40);

        // R6 hardware set beats clear in same cycle
        @(negedge clk); wr_en = 1'b1; addr = 1'b1; wdata = 8'h00; rst_start = 1'b1;
        @(negedge clk); wr_en = 1'b0; rst_start = 1'b0;
        rd(1'b1, v); chk("R6 hw set wins", v, 8'h40);
        wr(1'b1, 8'h00);
        rd(1'b1, v); chk("R6 clear bit6", v, 8'h00);

        // R1 reset again restores defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(1'b1, v); chk("R1 re-reset ctrl", v, 8'h06);
        rd(1'b0, v); chk("R1 re-reset mask", v, 8'h00);

        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

endmodule